// File: doc/BRIEF.md
# Hysteretic Fan Speed Controller

This block turns a stream of die temperature samples into a fan speed command in RPM and a fan-on flag. Each time a new sample arrives with its valid strobe, the controller decides whether the fan should run. While the fan runs, the controller also moves the commanded speed one programmable step toward holding the die at a target temperature. Between samples both outputs hold their values.

Stopping the fan is optional and has two thresholds. When the stop feature is enabled and the die is cooler than a low threshold, the fan stops and the command drops to zero. A stopped fan waits until the die is hotter than a separate, higher threshold, so the fan does not turn on and off repeatedly near a single temperature. A running fan always stays between a minimum and a maximum speed. Both limits are given as 8-bit codes in units of 100 RPM.

After reset, and until the first sample arrives, the fan runs at the maximum speed. The controller is a three-state machine. BOOT is the post-reset state at full speed. RUN is regulation between the limits. STOP is the zero-speed state. The transitions are: boot_to_run and boot_to_stop, taken on the first sample; run_to_stop, taken when the die is cooler than the stop threshold; stop_to_run, taken when the die is hotter than the start threshold or when stopping is disabled. Each state also has a hold transition, taken whenever no sample is present.

Top module: `thermal_fan_ctrl`

## Requirements
- R1: After reset and before the first valid sample, fan_on is 1 and rpm_cmd equals cfg_max_code times 100.
- R2: On a valid sample with cfg_zero_en=1 and temp_sample strictly below cfg_stop_temp, the fan stops: fan_on goes to 0 and rpm_cmd goes to 0. A sample equal to cfg_stop_temp does not stop the fan.
- R3: A stopped fan restarts only on a valid sample strictly above cfg_start_temp. When it restarts, fan_on becomes 1 and rpm_cmd becomes the minimum speed. A sample at or below cfg_start_temp leaves the fan stopped.
- R4: While the fan is running, each valid sample changes the speed by one step. A sample above cfg_target_temp adds cfg_step_rpm, a sample below it subtracts cfg_step_rpm, and a sample equal to it leaves the speed unchanged.
- R5: A running speed is saturated to the range [cfg_min_code*100, cfg_max_code*100] RPM. The codes are unsigned 8-bit values in units of 100 RPM, so a code of 255 means 25500 RPM.
- R6: With cfg_zero_en=0 the fan never stops. If the fan is already stopped, the next valid sample restarts it at the minimum speed, whatever the temperature.
- R7: The outputs change only in the cycle after a clock edge at which temp_valid=1. Without a valid sample, changes to temp_sample or to the thresholds, target or step have no effect on the outputs.

All temperatures are unsigned integers in degrees Celsius.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_valid | input | 1 | Strobe marking a new temperature sample |
| temp_sample | input | TEMP_W | Die temperature, in °C |
| cfg_stop_temp | input | TEMP_W | The fan stops when the die is strictly below this value |
| cfg_start_temp | input | TEMP_W | A stopped fan restarts when the die is strictly above this value |
| cfg_target_temp | input | TEMP_W | Regulation target temperature |
| cfg_min_code | input | CODE_W | Minimum running speed, in units of 100 RPM |
| cfg_max_code | input | CODE_W | Maximum speed, in units of 100 RPM |
| cfg_step_rpm | input | RPM_W | Speed change applied per sample |
| cfg_zero_en | input | 1 | Allows the fan to stop |
| rpm_cmd | output | RPM_W | Fan speed command, in RPM |
| fan_on | output | 1 | 1 while the fan is commanded to run |

## Verification
The bench builds the block with its default parameters: 8-bit temperatures, 8-bit speed codes and a 16-bit RPM command. These widths make the full code range reachable, up to 25500 RPM. One test sends samples that push the speed past that ceiling, which checks saturation at the top of the range. The table walk covers samples that are exactly equal to the stop, start and target values, so it checks that the thresholds are strict and that the speed holds at the target. The directed tests check that the stop feature can be disabled while the fan runs and while it is stopped, that changes on the inputs without a valid strobe have no effect, and that a reset in the middle of a run returns the fan to full speed.

// File: rtl/fanctl_pkg.sv
package fanctl_pkg;
    typedef enum logic [1:0] {
        FC_BOOT = 2'd0,
        FC_RUN  = 2'd1,
        FC_STOP = 2'd2
    } fc_state_e;

    localparam int unsigned RPM_PER_CODE = 100;
endpackage

// File: rtl/fanctl_code_scale.sv
module fanctl_code_scale #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned RPM_W  = 16
) (
    input  logic [CODE_W-1:0] code,
    output logic [RPM_W-1:0]  rpm
);
    localparam int unsigned PROD_W = RPM_W + 8;
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(code) * PROD_W'(fanctl_pkg::RPM_PER_CODE);
        rpm  = prod[RPM_W-1:0];
    end
endmodule

// File: rtl/fanctl_temp_cmp.sv
module fanctl_temp_cmp #(
    parameter int unsigned TEMP_W = 8
) (
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] stop_temp,
    input  logic [TEMP_W-1:0] start_temp,
    input  logic [TEMP_W-1:0] target_temp,
    output logic              below_stop,
    output logic              above_start,
    output logic              above_target,
    output logic              below_target
);
    always_comb begin
        below_stop   = temp < stop_temp;
        above_start  = temp > start_temp;
        above_target = temp > target_temp;
        below_target = temp < target_temp;
    end
endmodule

// File: rtl/fanctl_stepper.sv
module fanctl_stepper #(
    parameter int unsigned RPM_W = 16
) (
    input  logic [RPM_W-1:0] cur_rpm,
    input  logic [RPM_W-1:0] step_rpm,
    input  logic             go_up,
    input  logic             go_down,
    input  logic [RPM_W-1:0] lo_rpm,
    input  logic [RPM_W-1:0] hi_rpm,
    output logic [RPM_W-1:0] next_rpm
);
    localparam int unsigned EXT_W = RPM_W + 1;
    logic [EXT_W-1:0] raw;

    always_comb begin
        if (go_up) begin
            raw = EXT_W'(cur_rpm) + EXT_W'(step_rpm);
        end else if (go_down) begin
            raw = (step_rpm > cur_rpm) ? '0 : EXT_W'(cur_rpm - step_rpm);
        end else begin
            raw = EXT_W'(cur_rpm);
        end
        if (raw > EXT_W'(hi_rpm)) begin
            next_rpm = hi_rpm;
        end else if (raw < EXT_W'(lo_rpm)) begin
            next_rpm = lo_rpm;
        end else begin
            next_rpm = raw[RPM_W-1:0];
        end
    end
endmodule

// File: rtl/thermal_fan_ctrl.sv
module thermal_fan_ctrl #(
    parameter int unsigned TEMP_W = 8,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned RPM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_sample,
    input  logic [TEMP_W-1:0] cfg_stop_temp,
    input  logic [TEMP_W-1:0] cfg_start_temp,
    input  logic [TEMP_W-1:0] cfg_target_temp,
    input  logic [CODE_W-1:0] cfg_min_code,
    input  logic [CODE_W-1:0] cfg_max_code,
    input  logic [RPM_W-1:0]  cfg_step_rpm,
    input  logic              cfg_zero_en,
    output logic [RPM_W-1:0]  rpm_cmd,
    output logic              fan_on
);
    import fanctl_pkg::*;

    localparam int unsigned N_LIMITS = 2;

    fc_state_e         state_q, state_d;
    logic [RPM_W-1:0]  rpm_q, rpm_d;
    logic [CODE_W-1:0] lim_code [N_LIMITS];
    logic [RPM_W-1:0]  lim_rpm  [N_LIMITS];
    logic [RPM_W-1:0]  min_rpm, max_rpm, cur_rpm, stepped_rpm;
    logic below_stop, above_start, above_target, below_target;

    assign lim_code[0] = cfg_min_code;
    assign lim_code[1] = cfg_max_code;

    for (genvar gi = 0; gi < N_LIMITS; gi++) begin : g_scale
        fanctl_code_scale #(.CODE_W(CODE_W), .RPM_W(RPM_W)) u_scale (
            .code (lim_code[gi]),
            .rpm  (lim_rpm[gi])
        );
    end

    assign min_rpm = lim_rpm[0];
    assign max_rpm = lim_rpm[1];

    fanctl_temp_cmp #(.TEMP_W(TEMP_W)) u_cmp (
        .temp         (temp_sample),
        .stop_temp    (cfg_stop_temp),
        .start_temp   (cfg_start_temp),
        .target_temp  (cfg_target_temp),
        .below_stop   (below_stop),
        .above_start  (above_start),
        .above_target (above_target),
        .below_target (below_target)
    );

    // Before the first sample the fan runs at the ceiling, so stepping starts there.
    assign cur_rpm = (state_q == FC_BOOT) ? max_rpm : rpm_q;

    fanctl_stepper #(.RPM_W(RPM_W)) u_step (
        .cur_rpm  (cur_rpm),
        .step_rpm (cfg_step_rpm),
        .go_up    (above_target),
        .go_down  (below_target),
        .lo_rpm   (min_rpm),
        .hi_rpm   (max_rpm),
        .next_rpm (stepped_rpm)
    );

    // Next-state and next-speed decision, evaluated for a valid sample.
    always_comb begin
        state_d = state_q;
        rpm_d   = rpm_q;
        unique case (state_q)
            FC_BOOT, FC_RUN: begin
                if (cfg_zero_en && below_stop) begin
                    state_d = FC_STOP;
                    rpm_d   = '0;
                end else begin
                    state_d = FC_RUN;
                    rpm_d   = stepped_rpm;
                end
            end
            FC_STOP: begin
                if (!cfg_zero_en || above_start) begin
                    state_d = FC_RUN;
                    rpm_d   = min_rpm;
                end else begin
                    state_d = FC_STOP;
                    rpm_d   = '0;
                end
            end
            default: begin
                state_d = FC_BOOT;
                rpm_d   = '0;
            end
        endcase
    end

    // State register: advances only on a valid sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_BOOT;
            rpm_q   <= '0;
        end else if (temp_valid) begin
            state_q <= state_d;
            rpm_q   <= rpm_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            FC_BOOT: begin
                fan_on  = 1'b1;
                rpm_cmd = max_rpm;
            end
            FC_RUN: begin
                fan_on  = 1'b1;
                rpm_cmd = rpm_q;
            end
            FC_STOP: begin
                fan_on  = 1'b0;
                rpm_cmd = '0;
            end
            default: begin
                fan_on  = 1'b1;
                rpm_cmd = max_rpm;
            end
        endcase
    end
endmodule

// File: rtl/fanctl_checker.sv
module fanctl_checker #(
    parameter int unsigned TEMP_W = 8,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned RPM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              temp_valid,
    input logic [TEMP_W-1:0] temp_sample,
    input logic [TEMP_W-1:0] cfg_stop_temp,
    input logic [TEMP_W-1:0] cfg_start_temp,
    input logic [CODE_W-1:0] cfg_min_code,
    input logic [CODE_W-1:0] cfg_max_code,
    input logic              cfg_zero_en,
    input logic [RPM_W-1:0]  rpm_cmd,
    input logic              fan_on
);
    logic [31:0] lo_lim, hi_lim;
    assign lo_lim = 32'(cfg_min_code) * 32'd100;
    assign hi_lim = 32'(cfg_max_code) * 32'd100;

    // R2: a stopped fan commands zero speed
    a_r2_off_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !fan_on |-> rpm_cmd == '0);

    // R2: the fan stops only on a sample strictly below the stop threshold
    a_r2_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fan_on) |-> ($past(temp_valid) && $past(cfg_zero_en)
                           && ($past(temp_sample) < $past(cfg_stop_temp))));

    // R3: a restart needs a sample strictly above the start threshold, or stopping disabled
    a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fan_on) |-> ($past(temp_valid) && (!$past(cfg_zero_en)
                           || ($past(temp_sample) > $past(cfg_start_temp)))));

    // R5: after a sample, a running speed lies inside the limits
    a_r5_within_limits: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid && cfg_min_code <= cfg_max_code) |=>
        (!fan_on || (32'(rpm_cmd) >= $past(lo_lim) && 32'(rpm_cmd) <= $past(hi_lim))));

    // R6: with stopping disabled, every sample leaves the fan running
    a_r6_never_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid && !cfg_zero_en) |=> fan_on);

    // R7: the outputs hold when no sample is present
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> $stable(fan_on));

    a_r7_rpm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> ($stable(cfg_max_code) -> $stable(rpm_cmd)));
endmodule

bind thermal_fan_ctrl fanctl_checker #(
    .TEMP_W(TEMP_W), .CODE_W(CODE_W), .RPM_W(RPM_W)
) u_fanctl_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .temp_valid     (temp_valid),
    .temp_sample    (temp_sample),
    .cfg_stop_temp  (cfg_stop_temp),
    .cfg_start_temp (cfg_start_temp),
    .cfg_min_code   (cfg_min_code),
    .cfg_max_code   (cfg_max_code),
    .cfg_zero_en    (cfg_zero_en),
    .rpm_cmd        (rpm_cmd),
    .fan_on         (fan_on)
);

// File: tb/tb_thermal_fan_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_fan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        temp_valid = 1'b0;
    logic [7:0]  temp_sample = 8'd0;
    logic [7:0]  cfg_stop_temp = 8'd40;
    logic [7:0]  cfg_start_temp = 8'd45;
    logic [7:0]  cfg_target_temp = 8'd70;
    logic [7:0]  cfg_min_code = 8'd10;
    logic [7:0]  cfg_max_code = 8'd40;
    logic [15:0] cfg_step_rpm = 16'd200;
    logic        cfg_zero_en = 1'b1;
    logic [15:0] rpm_cmd;
    logic        fan_on;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    thermal_fan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_sample(temp_sample),
        .cfg_stop_temp(cfg_stop_temp), .cfg_start_temp(cfg_start_temp),
        .cfg_target_temp(cfg_target_temp), .cfg_min_code(cfg_min_code),
        .cfg_max_code(cfg_max_code), .cfg_step_rpm(cfg_step_rpm),
        .cfg_zero_en(cfg_zero_en), .rpm_cmd(rpm_cmd), .fan_on(fan_on)
    );

    // Table: stop 40, start 45, target 70, limits 1000..4000, step 200, stopping enabled.
    localparam int NV = 13;
    localparam logic [7:0]  V_TEMP [NV] = '{8'd75, 8'd65, 8'd65, 8'd70, 8'd72, 8'd42, 8'd40,
                                           8'd39, 8'd44, 8'd45, 8'd46, 8'd50, 8'd71};
    localparam logic        V_ON   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                           1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [15:0] V_RPM  [NV] = '{16'd4000, 16'd3800, 16'd3600, 16'd3600, 16'd3800,
                                           16'd3600, 16'd3400, 16'd0, 16'd0, 16'd0,
                                           16'd1000, 16'd1000, 16'd1200};
    localparam string       V_REQ  [NV] = '{"R5", "R4", "R4", "R4", "R4", "R4", "R2",
                                           "R2", "R3", "R3", "R3", "R5", "R4"};

    task automatic check(input string req, input logic on_exp, input logic [15:0] rpm_exp);
        n_tests++;
        if (fan_on !== on_exp || rpm_cmd !== rpm_exp) begin
            n_fail++;
            $display("FAIL %s: fan_on=%0b rpm=%0d expected fan_on=%0b rpm=%0d",
                     req, fan_on, rpm_cmd, on_exp, rpm_exp);
        end
    endtask

    // Drive at negedge, let the posedge capture it, sample at the next negedge.
    task automatic sample(input logic [7:0] t);
        temp_sample = t;
        temp_valid  = 1'b1;
        @(negedge clk);
        temp_valid  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b1, 16'd4000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 before first sample", 1'b1, 16'd4000);

        for (int i = 0; i < NV; i++) begin
            sample(V_TEMP[i]);
            check(V_REQ[i], V_ON[i], V_RPM[i]);
        end

        // R7: input changes with no valid strobe are ignored
        temp_sample = 8'd10; cfg_target_temp = 8'd20; cfg_step_rpm = 16'd900;
        cfg_stop_temp = 8'd90;
        repeat (3) @(negedge clk);
        check("R7 no strobe", 1'b1, 16'd1200);
        cfg_target_temp = 8'd70; cfg_step_rpm = 16'd200; cfg_stop_temp = 8'd40;

        // R6: stopping disabled while running
        cfg_zero_en = 1'b0;
        sample(8'd30);
        check("R6 cold, stop disabled", 1'b1, 16'd1000);
        sample(8'd30);
        check("R6 stays at minimum", 1'b1, 16'd1000);
        cfg_zero_en = 1'b1;
        sample(8'd30);
        check("R2 stop re-enabled", 1'b0, 16'd0);
        // R6: stopping disabled while stopped restarts at minimum
        cfg_zero_en = 1'b0;
        sample(8'd30);
        check("R6 restart from stop", 1'b1, 16'd1000);

        // R5: full code range, ceiling 25500
        cfg_min_code = 8'd250; cfg_max_code = 8'd255;
        sample(8'd90);
        check("R5 raised to floor 25000", 1'b1, 16'd25000);
        sample(8'd90);
        check("R5 step 25200", 1'b1, 16'd25200);
        sample(8'd90);
        check("R5 step 25400", 1'b1, 16'd25400);
        sample(8'd90);
        check("R5 saturate 25500", 1'b1, 16'd25500);

        // R1: reset mid-run returns to full speed
        cfg_min_code = 8'd10; cfg_max_code = 8'd40; cfg_zero_en = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after mid-run reset", 1'b1, 16'd4000);
        sample(8'd20);
        check("R2 first sample cold", 1'b0, 16'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule